// File: doc/BRIEF.md
# Microcoded Memory-Cycle Sequencer with Per-Bank Guard Timer

The block drives external memory accesses from short programs of control words. Several pattern engines each own a writable pattern RAM of 64 words. There are four chip-select banks, and each bank's engine-select field names the engine that serves it. A request names a bank and a direction. The serving engine then steps through its RAM from a read or a write start index, one word per clock. In each cycle the current word sets the level of that bank's chip-select and of the engine's transfer-acknowledge.

A word can end the program. A word that ends the program can also start a guard timer for its bank. While the timer runs, the bank's chip-select stays at the level of the final word for the bank's programmed gap, and a new request to that bank is held off. This lets DRAM precharge complete, for example. Other banks do not see the timer. Requests use a ready/valid handshake, so a stalled request waits and is never dropped.

Top module: `mem_seq_top`

## Requirements
- R1: A request to bank b is executed by the engine named in bank b's select field (bank_eng_i[b]). Only bank b's chip-select is driven by that access.
- R2: A control word's bit 0 set drives the accessed bank's cs_n_o low in that word's cycle. The pointer starts at the engine's read start index (read) or write start index (write), advances by one per clock, and wraps from 63 to 0.
- R3: Bit 2 (end) marks the final word. Its bit 0 applies to that final cycle, and the engine is idle in the next cycle.
- R4: Bit 3 (guard) together with bit 2 in the same word, on a bank whose gap g is not 0, holds that bank's chip-select at the final word's level for g clocks after the final cycle. Bit 3 without bit 2 has no effect.
- R5: While a bank's guard timer runs, req_ready_o is low for requests to that bank. The next same-bank request is accepted len+g+1 edges after the previous one, where len is the program length.
- R6: A running guard timer does not delay a request to any other bank. Such a request waits only for its own engine.
- R7: A gap of 0 enforces no pause. A same-bank request is accepted len+1 edges after the previous one.
- R8: Bit 1 drives ta_o[e] for a read in any word. For a write, ta_o[e] is asserted only in a word where bit 1 and bit 2 are both set.
- R9: req_ready_o is high exactly when the requested bank's engine is idle and that bank's timer is not running. A held request is accepted on the first edge at which ready is high.
- R10: After reset every cs_n_o is high, ta_o is 0, the timers are cleared and req_ready_o is high.
- R11: The load port writes ld_data_i into the RAM of engine ld_eng_i at ld_addr_i, and later accesses use the new word.
- R12: Engines run concurrently: a request to a bank served by an idle engine is accepted while another engine is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_bank_i | input | BW | Target bank |
| req_write_i | input | 1 | 1 = write program, 0 = read program |
| req_ready_o | output | 1 | Request can be accepted |
| ld_en_i | input | 1 | Pattern RAM write strobe |
| ld_eng_i | input | EW | Engine whose RAM is written |
| ld_addr_i | input | AW | RAM word address |
| ld_data_i | input | 32 | Control word to store |
| bank_eng_i | input | NB*EW | Engine-select field per bank |
| bank_gap_i | input | NB*GW | Guard gap in clocks per bank |
| rd_start_i | input | NE*AW | Read program start index per engine |
| wr_start_i | input | NE*AW | Write program start index per engine |
| cs_n_o | output | NB | Chip-selects, active low |
| ta_o | output | NE | Transfer-acknowledge per engine |

## Verification
The main function is exercised with several request patterns. Back-to-back requests to one guarded bank show whether the timer length and the held chip-select level are right. A guarded bank followed at once by a bank on another engine separates the per-bank timer from an engine-wide stall. A bank that shares the busy engine shows that only the engine, not the timer, delays it. A write program with the guard bit in a non-final word, a gap-0 bank and a program that runs past index 63 cover the ignored bit, the no-gap case and pointer wrap. A RAM reload shows that a changed program length appears in the handshake timing.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int CW_W = 32;
  typedef struct packed {
    logic [CW_W-5:0] rsvd;
    logic            guard;
    logic            fin;
    logic            ack;
    logic            cs;
  } cw_t;
endpackage

// File: rtl/seq_pattern_ram.sv
module seq_pattern_ram #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/seq_engine.sv
module seq_engine import mseq_pkg::*; #(
  parameter int AW = 6,
  parameter int BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_ptr_i,
  input  logic [BW-1:0] bank_i,
  input  logic          write_i,
  input  cw_t           word_i,
  output logic [AW-1:0] ptr_o,
  output logic          busy_o,
  output logic [BW-1:0] bank_o,
  output logic          write_o,
  output logic          cs_o,
  output logic          ta_o,
  output logic          last_o,
  output logic          ten_o
);
  logic          busy_q, wr_q;
  logic [AW-1:0] ptr_q;
  logic [BW-1:0] bank_q;
  logic          unused_rsvd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      bank_q <= '0;
      wr_q   <= 1'b0;
    end else if (busy_q) begin
      if (word_i.fin) busy_q <= 1'b0;
      else            ptr_q  <= ptr_q + 1'b1;  // wraps at depth
    end else if (start_i) begin
      busy_q <= 1'b1;
      ptr_q  <= start_ptr_i;
      bank_q <= bank_i;
      wr_q   <= write_i;
    end
  end

  assign unused_rsvd = ^word_i.rsvd;
  assign ptr_o   = ptr_q;
  assign busy_o  = busy_q;
  assign bank_o  = bank_q;
  assign write_o = wr_q;
  assign cs_o    = busy_q & word_i.cs;
  assign last_o  = busy_q & word_i.fin;
  // guard bit only counts in a final word
  assign ten_o   = busy_q & word_i.fin & word_i.guard;
  // writes acknowledge only in the final word
  assign ta_o    = busy_q & word_i.ack & (~wr_q | word_i.fin);
endmodule

// File: rtl/bank_guard.sv
module bank_guard #(
  parameter int GW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [GW-1:0] gap_i,
  input  logic          lvl_i,
  output logic          busy_o,
  output logic          hold_o
);
  logic [GW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= gap_i;
      lvl_q <= lvl_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign hold_o = busy_o & lvl_q;
endmodule

// File: rtl/mem_seq_top.sv
module mem_seq_top import mseq_pkg::*; #(
  parameter int NB    = 4,
  parameter int NE    = 2,
  parameter int DEPTH = 64,
  parameter int GW    = 8,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1,
  localparam int EW   = (NE > 1) ? $clog2(NE) : 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [BW-1:0]    req_bank_i,
  input  logic             req_write_i,
  output logic             req_ready_o,
  input  logic             ld_en_i,
  input  logic [EW-1:0]    ld_eng_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [CW_W-1:0]  ld_data_i,
  input  logic [NB*EW-1:0] bank_eng_i,
  input  logic [NB*GW-1:0] bank_gap_i,
  input  logic [NE*AW-1:0] rd_start_i,
  input  logic [NE*AW-1:0] wr_start_i,
  output logic [NB-1:0]    cs_n_o,
  output logic [NE-1:0]    ta_o
);
  logic [EW-1:0] req_eng;
  logic          accept;
  logic [NE-1:0] eng_busy, eng_start, eng_cs, eng_last, eng_ten, eng_write, req_eng_oh;
  logic [BW-1:0] eng_bank [NE];
  logic [NB-1:0] guard_ld, guard_busy, guard_hold, bank_act;

  assign req_eng     = bank_eng_i[int'(req_bank_i)*EW +: EW];
  assign req_ready_o = ~eng_busy[req_eng] & ~guard_busy[req_bank_i];
  assign accept      = req_valid_i & req_ready_o;

  for (genvar e = 0; e < NE; e++) begin : g_eng
    logic [CW_W-1:0] rd_word;
    logic [AW-1:0]   ptr;
    logic [AW-1:0]   sptr;

    assign req_eng_oh[e] = (req_eng == EW'(e));
    assign eng_start[e]  = accept & req_eng_oh[e];
    assign sptr = req_write_i ? wr_start_i[e*AW +: AW] : rd_start_i[e*AW +: AW];

    seq_pattern_ram #(.DEPTH(DEPTH), .W(CW_W)) u_ram (
      .clk_i   (clk_i),
      .we_i    (ld_en_i && (ld_eng_i == EW'(e))),
      .waddr_i (ld_addr_i),
      .wdata_i (ld_data_i),
      .raddr_i (ptr),
      .rdata_o (rd_word)
    );

    seq_engine #(.AW(AW), .BW(BW)) u_eng (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (eng_start[e]),
      .start_ptr_i (sptr),
      .bank_i      (req_bank_i),
      .write_i     (req_write_i),
      .word_i      (cw_t'(rd_word)),
      .ptr_o       (ptr),
      .busy_o      (eng_busy[e]),
      .bank_o      (eng_bank[e]),
      .write_o     (eng_write[e]),
      .cs_o        (eng_cs[e]),
      .ta_o        (ta_o[e]),
      .last_o      (eng_last[e]),
      .ten_o       (eng_ten[e])
    );
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          act, on, ld, lvl;
    logic [GW-1:0] gap;

    always_comb begin
      act = 1'b0;
      on  = 1'b0;
      ld  = 1'b0;
      lvl = 1'b0;
      for (int e = 0; e < NE; e++) begin
        if (eng_bank[e] == BW'(b)) begin
          act = act | eng_busy[e];
          on  = on  | eng_cs[e];
          ld  = ld  | eng_ten[e];
          lvl = lvl | (eng_ten[e] & eng_cs[e]);
        end
      end
    end

    assign gap         = bank_gap_i[b*GW +: GW];
    assign guard_ld[b] = ld & (gap != '0);
    assign bank_act[b] = act;

    bank_guard #(.GW(GW)) u_grd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (guard_ld[b]),
      .gap_i  (gap),
      .lvl_i  (lvl),
      .busy_o (guard_busy[b]),
      .hold_o (guard_hold[b])
    );

    assign cs_n_o[b] = ~(on | guard_hold[b]);
  end
endmodule

// File: rtl/mem_seq_chk.sv
module mem_seq_chk #(
  parameter int NB = 4,
  parameter int NE = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic [NE-1:0] req_eng_oh,
  input logic [NE-1:0] eng_busy,
  input logic [NE-1:0] eng_last,
  input logic [NE-1:0] eng_write,
  input logic [NE-1:0] ta_o,
  input logic [NB-1:0] guard_ld,
  input logic [NB-1:0] guard_busy,
  input logic [NB-1:0] bank_act,
  input logic [NB-1:0] cs_n_o
);
  a_r3_final_word_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|eng_last) |=> ((eng_busy & $past(eng_last)) == '0));

  a_r4_guard_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|guard_ld) |=> ((guard_busy & $past(guard_ld)) == $past(guard_ld)));

  a_r8_write_ack_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ta_o & eng_write)) |-> ((ta_o & eng_write & ~eng_last) == '0));

  a_r2_cs_has_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~cs_n_o) & ~(bank_act | guard_busy)) == '0);

  a_r9_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ((eng_busy & $past(req_eng_oh)) != '0));
endmodule

bind mem_seq_top mem_seq_chk #(.NB(NB), .NE(NE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_eng_oh  (req_eng_oh),
  .eng_busy    (eng_busy),
  .eng_last    (eng_last),
  .eng_write   (eng_write),
  .ta_o        (ta_o),
  .guard_ld    (guard_ld),
  .guard_busy  (guard_busy),
  .bank_act    (bank_act),
  .cs_n_o      (cs_n_o)
);

// File: tb/sim_mem_seq_top.sv
`timescale 1ns/1ps
module sim_mem_seq_top;
  localparam int NB = 4, NE = 2, GW = 8, BW = 2, EW = 1, AW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0, req_write = 1'b0;
  logic [BW-1:0]    req_bank = '0;
  logic             req_ready;
  logic             ld_en = 1'b0;
  logic [EW-1:0]    ld_eng = '0;
  logic [AW-1:0]    ld_addr = '0;
  logic [31:0]      ld_data = '0;
  logic [NB*EW-1:0] bank_eng = 4'b1010;               // b0,b2->e0  b1,b3->e1
  logic [NB*GW-1:0] bank_gap = {8'd2, 8'd5, 8'd0, 8'd3};
  logic [NE*AW-1:0] rd_start = {6'd16, 6'd0};
  logic [NE*AW-1:0] wr_start = {6'd24, 6'd8};
  logic [NB-1:0]    cs_n;
  logic [NE-1:0]    ta;

  mem_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_bank_i(req_bank),
    .req_write_i(req_write), .req_ready_o(req_ready), .ld_en_i(ld_en), .ld_eng_i(ld_eng),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .bank_eng_i(bank_eng), .bank_gap_i(bank_gap),
    .rd_start_i(rd_start), .wr_start_i(wr_start), .cs_n_o(cs_n), .ta_o(ta)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int          m_busy[NE], m_ptr[NE], m_bank[NE], m_wr[NE];
  int          m_tmr[NB], m_lvl[NB];
  logic [31:0] m_mem[NE][64];

  function automatic int gap_of(int b); return int'(bank_gap[b*GW +: GW]); endfunction
  function automatic int eng_of(int b); return int'(bank_eng[b]); endfunction

  always @(negedge clk) begin
    logic [NB-1:0] e_cs;
    logic [NE-1:0] e_ta;
    logic          e_rdy;
    logic [31:0]   w;
    e_cs = '1;
    e_ta = '0;
    if (!rst_n) begin
      for (int e = 0; e < NE; e++) begin m_busy[e] = 0; m_ptr[e] = 0; m_bank[e] = 0; m_wr[e] = 0; end
      for (int b = 0; b < NB; b++) begin m_tmr[b] = 0; m_lvl[b] = 0; end
    end
    for (int e = 0; e < NE; e++) if (m_busy[e] != 0) begin
      w = m_mem[e][m_ptr[e]];
      if (w[0]) e_cs[m_bank[e]] = 1'b0;
      if (w[1] && (m_wr[e] == 0 || w[2])) e_ta[e] = 1'b1;
    end
    for (int b = 0; b < NB; b++) if (m_tmr[b] > 0 && m_lvl[b] != 0) e_cs[b] = 1'b0;
    e_rdy = (m_busy[eng_of(int'(req_bank))] == 0) && (m_tmr[req_bank] == 0);
    if (!done) begin
      check("R1 R2 R3 R4 R10 cs_n", int'(cs_n), int'(e_cs));
      check("R8 ta", int'(ta), int'(e_ta));
      check("R5 R6 R9 ready", int'(req_ready), int'(e_rdy));
    end
    if (rst_n) begin
      for (int b = 0; b < NB; b++) if (m_tmr[b] > 0) m_tmr[b]--;
      for (int e = 0; e < NE; e++) begin
        if (m_busy[e] != 0) begin
          w = m_mem[e][m_ptr[e]];
          if (w[2]) begin
            m_busy[e] = 0;
            if (w[3] && gap_of(m_bank[e]) > 0) begin
              m_tmr[m_bank[e]] = gap_of(m_bank[e]);
              m_lvl[m_bank[e]] = int'(w[0]);
            end
          end else m_ptr[e] = (m_ptr[e] + 1) % 64;
        end else if (req_valid && e_rdy && eng_of(int'(req_bank)) == e) begin
          m_busy[e] = 1;
          m_ptr[e]  = req_write ? int'(wr_start[e*AW +: AW]) : int'(rd_start[e*AW +: AW]);
          m_bank[e] = int'(req_bank);
          m_wr[e]   = int'(req_write);
        end
      end
      if (ld_en) m_mem[ld_eng][ld_addr] = ld_data;
    end
  end

  task automatic load(int e, int a, logic [31:0] d);
    @(posedge clk); #2;
    ld_en = 1'b1; ld_eng = EW'(e); ld_addr = AW'(a); ld_data = d;
    @(posedge clk); #2;
    ld_en = 1'b0;
  endtask

  task automatic issue(int b, bit wr, output int t);
    req_valid = 1'b1; req_bank = BW'(b); req_write = wr;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    t = cyc;
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // word bits: 0 cs, 1 ack, 2 final, 3 guard
  initial begin
    int t0, t1, t2;
    for (int e = 0; e < NE; e++) for (int a = 0; a < 64; a++) m_mem[e][a] = '0;
    idle(3);
    #3 rst_n = 1'b1;
    @(negedge clk);
    check("R10 cs_n after reset", int'(cs_n), 15);
    check("R10 ta after reset", int'(ta), 0);
    check("R10 ready after reset", int'(req_ready), 1);
    // R11 programs
    load(0, 0, 32'h1);  load(0, 1, 32'h3);  load(0, 2, 32'hF);
    load(0, 8, 32'h9);  load(0, 9, 32'hABCD0003); load(0, 10, 32'hF);
    load(1, 16, 32'h3); load(1, 17, 32'hC);
    load(1, 24, 32'h9); load(1, 25, 32'h7);
    load(1, 62, 32'h1); load(1, 63, 32'h1); load(1, 0, 32'h7);
    idle(2);
    // R4 R5: guarded bank, len 3 gap 3
    issue(0, 0, t0); issue(0, 0, t1);
    check("R5 same-bank spacing", t1 - t0, 3 + 3 + 1);
    idle(12);
    // R6 R12: other engine accepted next edge; R9 shared engine waits
    issue(0, 0, t0); issue(1, 0, t1); issue(2, 1, t2);
    check("R12 other engine concurrent", t1 - t0, 1);
    check("R6 shared engine waits only for engine", t2 - t0, 3 + 1);
    idle(14);
    // R7 gap 0
    issue(1, 0, t0); issue(1, 0, t1);
    check("R7 zero gap spacing", t1 - t0, 2 + 1);
    idle(6);
    // R4 guard without final ignored
    issue(3, 1, t0); issue(3, 1, t1);
    check("R4 guard bit without final ignored", t1 - t0, 2 + 1);
    idle(6);
    // R8 write guard gap 5
    issue(2, 1, t0); issue(2, 1, t1);
    check("R8 R5 write program spacing", t1 - t0, 3 + 5 + 1);
    idle(12);
    // R2 wrap
    rd_start = {6'd62, 6'd0};
    idle(1);
    issue(3, 0, t0); issue(3, 0, t1);
    check("R2 wrap program length", t1 - t0, 3 + 1);
    idle(6);
    // R11 reload shortens program
    load(0, 0, 32'h5);
    idle(1);
    issue(0, 0, t0); issue(0, 0, t1);
    check("R11 reloaded word used", t1 - t0, 1 + 1);
    idle(6);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule